// File: doc/BRIEF.md
# Pixel Hit Latency Buffer

This block is the digital back end of a single pixel channel in a triggered readout array. A discriminator pulse on `hit_i` latches the current value of a timestamp bus that the whole array shares. The bus is Gray-coded and counts modulo a programmable period. The latched stamp stays in one of several independent delay units while the trigger latency runs. A unit ages its stamp against the running bus. When the age equals the programmed latency, the unit releases its hit and becomes free in that same cycle.

A strobe writes one bit into a small per-pixel event FIFO. Shared, Gray-coded external pointers select the slot for the write and the slot for the read. The bit written is 1 only when the strobe meets a unit that is releasing its hit. Otherwise the strobe writes 0, so every triggered event has a defined entry. Readout presents a Gray-coded read pointer and gets the stored bit on `hit_o` one clock later. A mask bit silences the pixel. A sticky flag records hits that were lost because every delay unit was occupied. A synchronous clear empties the delay units, the FIFO and that flag.

Top module: `pixel_latency_buffer`

## Requirements
- R1: When `hit_i` is high and `mask_i` is low at a clock edge, the stamp on `stamp_gray_i` is decoded from reflected-binary Gray code (binary bit i is the XOR of Gray bits i and above) and stored in the lowest-numbered free delay unit. A unit is free when it holds no hit.
- R2: A held hit matures in the cycle where (current stamp − stored stamp) mod (`period_m1_i`+1) equals `latency_i`, with 1 ≤ `latency_i` ≤ `period_m1_i`. If `strobe_i` is high in that cycle, a 1 is written into the FIFO slot addressed by `wr_gray_i`.
- R3: A strobe that meets no maturing hit writes 0 into the addressed slot. A hit that has not yet matured stays held through that strobe.
- R4: A maturing hit frees its unit at that clock edge whether or not a strobe is present. With no strobe it is discarded, and a later strobe writes 0.
- R5: With the default of two delay units, a second hit captured while the first is still held is kept and delivered at its own maturity.
- R6: A hit that finds every delay unit occupied is dropped and sets `ovf_o`. `ovf_o` then stays high until a clear or a reset.
- R7: While `mask_i` is high, `hit_i` loads no delay unit and sets no overflow.
- R8: Stamp ageing wraps at the programmed period. A hit captured near the end of the period matures after the bus has wrapped through 0.
- R9: A high `clr_i` empties every delay unit, writes 0 into every FIFO slot and lowers `ovf_o` at that edge.
- R10: FIFO slots are addressed by 2-bit Gray pointers (0→00, 1→01, 2→11, 3→10). `hit_o` shows the bit of the slot selected by `rd_gray_i` one clock edge after it is presented.
- R11: After reset, `hit_o` and `ovf_o` are 0, no delay unit is occupied and every FIFO slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the stamp bus advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of delay units, FIFO and overflow flag |
| hit_i | input | 1 | Discriminator hit pulse |
| mask_i | input | 1 | Pixel mask; high suppresses hits |
| stamp_gray_i | input | 8 | Shared Gray-coded timestamp bus |
| period_m1_i | input | 8 | Timestamp period minus one |
| latency_i | input | 8 | Trigger latency in stamp counts |
| strobe_i | input | 1 | Trigger strobe; writes one FIFO slot |
| wr_gray_i | input | 2 | Gray-coded FIFO write slot |
| rd_gray_i | input | 2 | Gray-coded FIFO read slot |
| hit_o | output | 1 | Registered event bit of the read slot |
| ovf_o | output | 1 | Sticky flag: a hit found every unit occupied |

## Verification
The hardest state to reach from the ports is the one where every delay unit is occupied at the moment a third hit arrives, with the earlier hits still due to mature on schedule. The bench drives the stamp bus itself from a counter, so it knows the exact stamp at each capture. It sends three hits on consecutive stamps and places strobes exactly at the stamps where the first two mature, plus one where the dropped third would have matured. The wrap case uses the same stamp bookkeeping: it captures a hit two counts before the period ends and strobes at the stamp reached after the wrap.

// File: rtl/pixbuf_pkg.sv
package pixbuf_pkg;
  parameter int STAMP_W_DEF    = 8;
  parameter int FIFO_DEPTH_DEF = 4;
  parameter int SLOTS_DEF      = 2;
endpackage

// File: rtl/pixbuf_gray_dec.sv
module pixbuf_gray_dec #(
  parameter int W = 8
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  // each binary bit is the parity of the Gray bits at and above it
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^gray_i[W-1:i];
  end
endmodule

// File: rtl/pixbuf_delay_unit.sv
module pixbuf_delay_unit #(
  parameter int STAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [STAMP_W-1:0] now_i,
  input  logic [STAMP_W-1:0] period_m1_i,
  input  logic [STAMP_W-1:0] latency_i,
  output logic               busy_o,
  output logic               mature_o
);
  localparam int EW = STAMP_W + 1;

  logic               busy_q;
  logic [STAMP_W-1:0] stamp_q;
  logic [EW-1:0]      age;

  // age of the held stamp, modulo period
  always_comb begin
    if (now_i >= stamp_q)
      age = EW'(now_i) - EW'(stamp_q);
    else
      age = EW'(now_i) + EW'(period_m1_i) + EW'(1) - EW'(stamp_q);
  end

  assign mature_o = busy_q && (age == EW'(latency_i));
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      busy_q  <= 1'b0;
      stamp_q <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      stamp_q <= now_i;
    end else if (mature_o) begin
      busy_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/pixbuf_event_fifo.sv
module pixbuf_event_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rdata_o
);
  logic [DEPTH-1:0] mem_q;
  logic             rd_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // registered read, old data on a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/pixel_latency_buffer.sv
module pixel_latency_buffer
  import pixbuf_pkg::*;
#(
  parameter int STAMP_W    = STAMP_W_DEF,
  parameter int FIFO_DEPTH = FIFO_DEPTH_DEF,
  parameter int SLOTS      = SLOTS_DEF,
  localparam int PTR_W     = $clog2(FIFO_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               hit_i,
  input  logic               mask_i,
  input  logic [STAMP_W-1:0] stamp_gray_i,
  input  logic [STAMP_W-1:0] period_m1_i,
  input  logic [STAMP_W-1:0] latency_i,
  input  logic               strobe_i,
  input  logic [PTR_W-1:0]   wr_gray_i,
  input  logic [PTR_W-1:0]   rd_gray_i,
  output logic               hit_o,
  output logic               ovf_o
);
  logic [STAMP_W-1:0] now_bin;
  logic [PTR_W-1:0]   wr_bin;
  logic [PTR_W-1:0]   rd_bin;
  logic [SLOTS-1:0]   busy_vec;
  logic [SLOTS-1:0]   load_vec;
  logic [SLOTS-1:0]   expire_vec;
  logic               capture;
  logic               coinc;
  logic               ovf_q;

  pixbuf_gray_dec #(.W(STAMP_W)) u_stamp_dec (.gray_i(stamp_gray_i), .bin_o(now_bin));
  pixbuf_gray_dec #(.W(PTR_W))   u_wr_dec    (.gray_i(wr_gray_i),    .bin_o(wr_bin));
  pixbuf_gray_dec #(.W(PTR_W))   u_rd_dec    (.gray_i(rd_gray_i),    .bin_o(rd_bin));

  assign capture = hit_i && !mask_i;

  // lowest free unit takes the new hit
  always_comb begin
    logic taken;
    taken    = 1'b0;
    load_vec = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (capture && !busy_vec[i] && !taken) begin
        load_vec[i] = 1'b1;
        taken       = 1'b1;
      end
    end
  end

  for (genvar u = 0; u < SLOTS; u++) begin : g_unit
    pixbuf_delay_unit #(.STAMP_W(STAMP_W)) u_dly (
      .clk        (clk),
      .rst        (rst),
      .clr_i      (clr_i),
      .load_i     (load_vec[u]),
      .now_i      (now_bin),
      .period_m1_i(period_m1_i),
      .latency_i  (latency_i),
      .busy_o     (busy_vec[u]),
      .mature_o   (expire_vec[u])
    );
  end

  assign coinc = |expire_vec;

  pixbuf_event_fifo #(.DEPTH(FIFO_DEPTH), .AW(PTR_W)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .we_i   (strobe_i),
    .waddr_i(wr_bin),
    .wdata_i(coinc),
    .raddr_i(rd_bin),
    .rdata_o(hit_o)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_i)                 ovf_q <= 1'b0;
    else if (capture && (&busy_vec))  ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/pixbuf_checker.sv
module pixbuf_checker #(
  parameter int SLOTS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             mask_i,
  input logic             hit_o,
  input logic             ovf_o,
  input logic [SLOTS-1:0] busy_vec,
  input logic [SLOTS-1:0] load_vec,
  input logic [SLOTS-1:0] expire_vec
);
  AST_MASK_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_i |-> (load_vec == '0)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_o && !clr_i) |=> ovf_o); // R6

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (busy_vec == '0) && !ovf_o); // R9

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_vec)); // R1

  AST_LOAD_FREE: assert property (@(posedge clk) disable iff (rst)
    (load_vec & busy_vec) == '0); // R5

  AST_MATURE_FREES: assert property (@(posedge clk) disable iff (rst)
    (expire_vec != '0) |=> ((busy_vec & $past(expire_vec)) == '0)); // R4

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!hit_o && !ovf_o && (busy_vec == '0))); // R11
endmodule

bind pixel_latency_buffer pixbuf_checker #(.SLOTS(SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_i     (clr_i),
  .mask_i    (mask_i),
  .hit_o     (hit_o),
  .ovf_o     (ovf_o),
  .busy_vec  (busy_vec),
  .load_vec  (load_vec),
  .expire_vec(expire_vec)
);

// File: tb/pixel_latency_buffer_tb_top.sv
module pixel_latency_buffer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       hit = 1'b0;
  logic       mask = 1'b0;
  logic [7:0] stamp_gray = '0;
  logic [7:0] period_m1 = 8'd15;
  logic [7:0] latency = 8'd5;
  logic       strobe = 1'b0;
  logic [1:0] wr_gray = '0;
  logic [1:0] rd_gray = '0;
  logic       hit_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;
  int stamp_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pixel_latency_buffer dut_i (
    .clk(clk), .rst(rst), .clr_i(clr), .hit_i(hit), .mask_i(mask),
    .stamp_gray_i(stamp_gray), .period_m1_i(period_m1), .latency_i(latency),
    .strobe_i(strobe), .wr_gray_i(wr_gray), .rd_gray_i(rd_gray),
    .hit_o(hit_o), .ovf_o(ovf_o)
  );

  function automatic logic [7:0] to_gray(input int v);
    logic [7:0] b;
    b = 8'(v);
    return b ^ (b >> 1);
  endfunction

  task automatic adv();
    @(negedge clk);
    stamp_cnt  = (stamp_cnt >= int'(period_m1)) ? 0 : stamp_cnt + 1;
    stamp_gray = to_gray(stamp_cnt);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_stamp(input int target);
    while (stamp_cnt != target) adv();
  endtask

  task automatic hit_pulse();
    hit = 1'b1; adv(); hit = 1'b0;
  endtask

  task automatic trig(input int slot);
    wr_gray = 2'(to_gray(slot)); strobe = 1'b1; adv(); strobe = 1'b0;
  endtask

  task automatic read_chk(input int slot, input logic exp, input string tag);
    rd_gray = 2'(to_gray(slot)); adv();
    chk(tag, hit_o, exp);
  endtask

  function automatic int due(input int s, input int k);
    return (s + k + int'(latency)) % (int'(period_m1) + 1);
  endfunction

  task automatic t_reset();
    chk("R11 hit_o after reset", hit_o, 1'b0);
    chk("R11 ovf after reset", ovf_o, 1'b0);
    for (int s = 0; s < 4; s++) read_chk(s, 1'b0, "R11 empty slot");
  endtask

  task automatic t_coinc();
    int s0;
    s0 = stamp_cnt; hit_pulse();
    wait_stamp(due(s0, 0)); trig(1);
    read_chk(1, 1'b1, "R2 R1 coincidence slot1");
  endtask

  task automatic t_early();
    int s0;
    s0 = stamp_cnt; hit_pulse(); adv();
    trig(2);
    wait_stamp(due(s0, 0)); trig(3);
    read_chk(2, 1'b0, "R3 early strobe writes 0");
    read_chk(3, 1'b1, "R3 held hit survives early strobe");
  endtask

  task automatic t_missed();
    int s0;
    s0 = stamp_cnt; hit_pulse();
    wait_stamp(due(s0, 0)); adv();
    trig(0);
    read_chk(0, 1'b0, "R4 missed hit discarded");
  endtask

  task automatic t_two();
    int s0;
    s0 = stamp_cnt; hit_pulse(); adv(); hit_pulse();
    wait_stamp(due(s0, 0)); trig(0);
    wait_stamp(due(s0, 2)); trig(1);
    read_chk(0, 1'b1, "R5 first unit");
    read_chk(1, 1'b1, "R5 second unit");
    chk("R5 no overflow", ovf_o, 1'b0);
  endtask

  task automatic t_overflow();
    int s0;
    s0 = stamp_cnt; hit_pulse(); hit_pulse(); hit_pulse();
    chk("R6 overflow set", ovf_o, 1'b1);
    wait_stamp(due(s0, 0)); trig(0);
    trig(1);
    trig(2);
    read_chk(0, 1'b1, "R6 first kept");
    read_chk(1, 1'b1, "R6 second kept");
    read_chk(2, 1'b0, "R6 third dropped");
    repeat (5) adv();
    chk("R6 overflow sticky", ovf_o, 1'b1);
  endtask

  task automatic t_mask();
    int s0;
    mask = 1'b1;
    s0 = stamp_cnt; hit_pulse();
    wait_stamp(due(s0, 0)); trig(3);
    mask = 1'b0;
    read_chk(3, 1'b0, "R7 masked hit suppressed");
  endtask

  task automatic t_clear();
    int s0;
    s0 = stamp_cnt; hit_pulse();
    clr = 1'b1; adv(); clr = 1'b0;
    chk("R9 overflow cleared", ovf_o, 1'b0);
    wait_stamp(due(s0, 0)); trig(0);
    read_chk(0, 1'b0, "R9 unit emptied");
    read_chk(1, 1'b0, "R9 fifo emptied");
  endtask

  task automatic t_wrap();
    period_m1 = 8'd9; latency = 8'd7;
    wait_stamp(8); hit_pulse();
    wait_stamp(5); trig(2);
    read_chk(2, 1'b1, "R8 wrap maturity");
  endtask

  task automatic t_readlat();
    read_chk(1, 1'b0, "R10 slot1 zero");
    rd_gray = 2'b11;
    #1 chk("R10 output not yet updated", hit_o, 1'b0);
    adv();
    chk("R10 gray 11 selects slot2", hit_o, 1'b1);
  endtask

  initial begin
    repeat (3) adv();
    rst = 1'b0;
    adv();
    t_reset();
    t_coinc();
    t_early();
    t_missed();
    t_two();
    t_overflow();
    t_mask();
    t_clear();
    t_wrap();
    t_readlat();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule